// File: doc/BRIEF.md
# Multi-Mode Preset Delay Timer

A hardware timer that behaves like the on-delay, off-delay and pulse timers found in industrial controllers. A two-bit mode input chooses the behaviour. A three-bit time-base select picks the length of one timing tick: 10 ms, 100 ms, 1 s, 10 s or 100 s. A prescaler builds that tick from the system clock, whose frequency is a parameter. The preset says how many ticks make up the timed interval, so a preset of 5 on the 100 ms base gives a 500 ms interval.

The timer input is registered once, and the enable output shows that registered copy. The timed output `q` and the elapsed tick count are worked out from registered state only. The elapsed count is given twice, once as a binary word and once as packed BCD, and it stops at the preset. A synchronous reset clears the timer at any moment, whether it is running or not.

The prescaler restarts from zero each time a new interval starts, so the first tick is always full length. The number of clock cycles in one tick is written P below. P equals CLK_HZ/100 multiplied by 10^k for time-base code k. The signals `mode` and `tbase` are control pins with no handshake. They are expected to stay steady while an interval is running.

Top module: `preset_delay_timer`

## Requirements
- R1: On-delay mode (mode 0, and mode 3 which acts the same) raises `q` exactly preset×P+1 clock edges after the edge that first samples `in_sig` high. With preset 0 this is the first such edge. `q` then stays high for as long as `in_sig` stays high.
- R2: In on-delay mode, a low `in_sig` drops `q` on the edge that samples it and clears the elapsed count one edge later. A later high input times a complete fresh interval, even if it was interrupted part way through a tick.
- R3: In off-delay mode (mode 1), `q` is high at every edge where `en` is high. After `in_sig` is sampled low, `q` falls exactly preset×P+1 edges later (at once for preset 0).
- R4: In off-delay mode, an input that goes high again during the hold-off time cancels the countdown. `q` stays high and the elapsed count returns to 0. The next fall times a complete interval.
- R5: In pulse mode (mode 2), a rising input gives a `q` pulse that starts two edges after the edge that samples it high and lasts exactly preset×P cycles. A preset of 0 gives no pulse.
- R6: In pulse mode, input edges that arrive while a pulse is active are ignored. The pulse keeps its original length, and no second pulse follows.
- R7: Time-base codes 0 to 4 select P = (CLK_HZ/100)×10^code. Codes 5 to 7 behave like code 4.
- R8: While timing, the elapsed count rises by one each tick, starting from 0. It stops at the preset and never wraps.
- R9: `et_bcd` holds the elapsed count in packed BCD with the least significant decimal digit in bits 3:0. It always matches `et_bin`.
- R10: A cycle with `rst` high leaves `q`, `en`, `et_bin` and `et_bcd` at zero, whatever state the timer was in before.
- R11: `en` equals the value of `in_sig` at the previous clock edge (zero just after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_sig | input | 1 | Timer input |
| mode | input | 2 | 0 on-delay, 1 off-delay, 2 pulse, 3 on-delay |
| tbase | input | 3 | Time-base code: 0 = 10 ms up to 4 = 100 s |
| preset | input | PW | Interval length in ticks |
| q | output | 1 | Timed output |
| en | output | 1 | Registered timer input |
| et_bin | output | PW | Elapsed ticks, binary |
| et_bcd | output | 4×DG | Elapsed ticks, packed BCD |

## Verification
The bench runs every mode across a range of presets and compares the exact edge at which `q` moves against preset×P+1. A timer whose prescaler does not restart, or that is off by one tick, misses that edge by some cycles. Interrupted on-delay intervals and re-raised off-delay inputs check that a restarted interval is not shortened by a leftover partial tick or a stale count. Retriggers inside a pulse catch a design that stretches the pulse or fires a second one. A sweep of all eight time-base codes, and a full count up to the largest preset, expose wrong decade scaling, wrap-around past the preset, and digit errors in the BCD conversion.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_ON_DELAY     = 2'd0,
    MODE_OFF_DELAY    = 2'd1,
    MODE_PULSE        = 2'd2,
    MODE_ON_DELAY_ALT = 2'd3
  } tmr_mode_e;

  // decade time bases: 10 ms .. 100 s
  localparam int unsigned NUM_BASES = 5;

  function automatic longint unsigned pow10(input int unsigned e);
    longint unsigned r = 1;
    for (int i = 0; i < 8; i++)
      if (i < int'(e)) r = r * 10;
    return r;
  endfunction

  // decimal digits needed for an all-ones word of width w
  function automatic int unsigned bcd_digits(input int unsigned w);
    longint unsigned v = (longint'(1) << w) - 1;
    int unsigned n = 1;
    for (int i = 0; i < 20; i++)
      if (v >= 10) begin
        v = v / 10;
        n++;
      end
    return n;
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 100_000_000,
  parameter int              SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam longint unsigned BASE_CYC = (CLK_HZ / 100 == 0) ? 1 : CLK_HZ / 100;
  localparam longint unsigned MAX_CYC  = BASE_CYC * pow10(NUM_BASES - 1);
  localparam int              CW       = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic [CW-1:0] last_cnt [NUM_BASES];
  logic [CW-1:0] lim;
  logic [CW-1:0] cnt;

  for (genvar g = 0; g < NUM_BASES; g++) begin : g_base
    assign last_cnt[g] = CW'(BASE_CYC * pow10(g) - 1);
  end

  // out-of-range codes fall back to the slowest base
  always_comb begin
    lim = last_cnt[NUM_BASES-1];
    for (int i = 0; i < NUM_BASES - 1; i++)
      if (sel == SEL_W'(i)) lim = last_cnt[i];
  end

  assign tick = run && (cnt == lim);

  // idle clears the divider so each interval starts with a whole tick
  always_ff @(posedge clk) begin
    if (rst || !run)     cnt <= '0;
    else if (cnt == lim) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/tmr_bcd.sv
module tmr_bcd #(
  parameter int BW = 8,
  parameter int DG = 3
) (
  input  logic [BW-1:0]   bin,
  output logic [4*DG-1:0] bcd
);

  function automatic logic [4*DG-1:0] convert(input logic [BW-1:0] b);
    logic [4*DG-1:0] r = '0;
    for (int i = BW - 1; i >= 0; i--) begin
      for (int d = 0; d < DG; d++)
        if (r[4*d +: 4] >= 4'd5) r[4*d +: 4] = r[4*d +: 4] + 4'd3;
      r = {r[4*DG-2:0], b[i]};
    end
    return r;
  endfunction

  assign bcd = convert(bin);

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_sig,
  input  tmr_mode_e     mode,
  input  logic [PW-1:0] preset,
  input  logic          tick,
  output logic          run,
  output logic          q,
  output logic          en,
  output logic [PW-1:0] acc
);

  logic in_q, in_qq, hold, active;
  logic below, rise;

  assign below = acc < preset;
  assign rise  = in_q & ~in_qq;
  assign en    = in_q;

  always_comb begin
    unique case (mode)
      MODE_OFF_DELAY: begin
        run = ~in_q & hold & below;
        q   = in_q | (hold & below);
      end
      MODE_PULSE: begin
        run = active & below;
        q   = active & below;
      end
      default: begin
        run = in_q & below;
        q   = in_q & ~below;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q   <= 1'b0;
      in_qq  <= 1'b0;
      hold   <= 1'b0;
      active <= 1'b0;
      acc    <= '0;
    end else begin
      in_q  <= in_sig;
      in_qq <= in_q;
      unique case (mode)
        MODE_OFF_DELAY: begin
          active <= 1'b0;
          if (in_q) begin
            hold <= 1'b1;
            acc  <= '0;
          end else if (hold) begin
            if (!below)    hold <= 1'b0;
            else if (tick) acc  <= acc + 1'b1;
          end
        end
        MODE_PULSE: begin
          hold <= 1'b0;
          if (rise && !active) begin
            active <= 1'b1;
            acc    <= '0;
          end else if (active) begin
            if (!below)    active <= 1'b0;
            else if (tick) acc    <= acc + 1'b1;
          end
        end
        default: begin
          hold   <= 1'b0;
          active <= 1'b0;
          if (!in_q)     acc <= '0;
          else if (tick) acc <= acc + 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/preset_delay_timer.sv
module preset_delay_timer
  import tmr_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 100_000_000,
  parameter int              PW     = 8,
  localparam int             DG     = bcd_digits(PW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_sig,
  input  logic [1:0]      mode,
  input  logic [2:0]      tbase,
  input  logic [PW-1:0]   preset,
  output logic            q,
  output logic            en,
  output logic [PW-1:0]   et_bin,
  output logic [4*DG-1:0] et_bcd
);

  logic tick, run;

  tmr_prescale #(.CLK_HZ(CLK_HZ), .SEL_W(3)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .sel  (tbase),
    .tick (tick)
  );

  tmr_core #(.PW(PW)) u_core (
    .clk    (clk),
    .rst    (rst),
    .in_sig (in_sig),
    .mode   (tmr_mode_e'(mode)),
    .preset (preset),
    .tick   (tick),
    .run    (run),
    .q      (q),
    .en     (en),
    .acc    (et_bin)
  );

  tmr_bcd #(.BW(PW), .DG(DG)) u_bcd (
    .bin (et_bin),
    .bcd (et_bcd)
  );

endmodule

// File: rtl/preset_delay_timer_chk.sv
module preset_delay_timer_chk
  import tmr_pkg::*;
#(
  parameter int PW = 8,
  parameter int DG = bcd_digits(PW)
) (
  input logic            clk,
  input logic            rst,
  input logic            in_sig,
  input logic [1:0]      mode,
  input logic [PW-1:0]   preset,
  input logic            q,
  input logic            en,
  input logic [PW-1:0]   et_bin,
  input logic [4*DG-1:0] et_bcd
);

  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  function automatic longint unsigned bcd_value(input logic [4*DG-1:0] v);
    longint unsigned s = 0;
    for (int d = DG - 1; d >= 0; d--) s = s * 10 + longint'(v[4*d +: 4]);
    return s;
  endfunction

  assert_reset_clears_R10: assert property (@(posedge clk)
    started && $past(rst) |-> (!q && !en && et_bin == '0 && et_bcd == '0));

  assert_en_follows_input_R11: assert property (@(posedge clk) disable iff (rst)
    started && !$past(rst) |-> en == $past(in_sig));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    started && !$past(rst) && et_bin != $past(et_bin)
      |-> ({1'b0, et_bin} == {1'b0, $past(et_bin)} + 1'b1) || et_bin == '0);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    started && !$past(rst) && $stable(preset) && $past(et_bin) <= preset
      |-> et_bin <= preset);

  assert_bcd_matches_R9: assert property (@(posedge clk) disable iff (rst)
    bcd_value(et_bcd) == longint'(et_bin));

  assert_on_delay_needs_en_R1: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 || mode == 2'd3) && q |-> en);

  assert_off_delay_follows_en_R3: assert property (@(posedge clk) disable iff (rst)
    mode == 2'd1 && en |-> q);

  assert_pulse_zero_preset_R5: assert property (@(posedge clk) disable iff (rst)
    mode == 2'd2 && preset == '0 |-> !q);

endmodule

bind preset_delay_timer preset_delay_timer_chk #(.PW(PW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .in_sig (in_sig),
  .mode   (mode),
  .preset (preset),
  .q      (q),
  .en     (en),
  .et_bin (et_bin),
  .et_bcd (et_bcd)
);

// File: tb/sim_preset_delay_timer.sv
module sim_preset_delay_timer;

  localparam int PW = 8;
  localparam int DG = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_sig = 1'b0;
  logic [1:0]      mode = 2'd0;
  logic [2:0]      tbase = 3'd0;
  logic [PW-1:0]   preset = '0;
  logic            q, en;
  logic [PW-1:0]   et_bin;
  logic [4*DG-1:0] et_bcd;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  preset_delay_timer #(.CLK_HZ(200), .PW(PW)) u0 (
    .clk(clk), .rst(rst), .in_sig(in_sig), .mode(mode), .tbase(tbase),
    .preset(preset), .q(q), .en(en), .et_bin(et_bin), .et_bcd(et_bcd)
  );

  // tick length in cycles: base is CLK_HZ/100 = 2
  function automatic int per(input int s);
    int r = 2;
    for (int i = 0; i < 4; i++) if (i < s) r = r * 10;
    return r;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic wait_q(input logic v, input int lim, output int k);
    k = -1;
    for (int i = 1; i <= lim; i++) begin
      step(1);
      if (q === v) begin
        k = i;
        break;
      end
    end
  endtask

  task automatic restart(input int md, input int tb, input int p);
    in_sig = 1'b0;
    rst = 1'b1;
    mode = 2'(md);
    tbase = 3'(tb);
    preset = PW'(p);
    step(2);
    rst = 1'b0;
  endtask

  int k;
  int cnt;
  longint dec;

  initial begin
    #(5ns * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(3);
    chk(q == 1'b0, "R10 reset q", q, 0);
    chk(en == 1'b0, "R10 reset en", en, 0);
    chk(et_bin == '0, "R10 reset et", et_bin, 0);

    // R1 on-delay sweep, modes 0 and 3
    for (int md = 0; md < 4; md += 3)
      for (int p = 0; p <= 12; p++) begin
        restart(md, 0, p);
        in_sig = 1'b1;
        wait_q(1'b1, 200, k);
        chk(k == p * 2 + 1, "R1 on-delay rise edge", k, p * 2 + 1);
        step(5);
        chk(q == 1'b1, "R1 q held", q, 1);
        chk(et_bin == PW'(p), "R8 count stops at preset", et_bin, p);
        chk(en == 1'b1, "R11 en high", en, 1);
        in_sig = 1'b0;
        step(1);
        chk(q == 1'b0, "R2 q drops with input", q, 0);
        chk(en == 1'b0, "R11 en low", en, 0);
        step(1);
        chk(et_bin == '0, "R2 count cleared", et_bin, 0);
      end

    // R2 interrupted interval, odd offset inside a tick
    restart(0, 1, 3);
    in_sig = 1'b1;
    step(27);
    in_sig = 1'b0;
    step(3);
    in_sig = 1'b1;
    wait_q(1'b1, 200, k);
    chk(k == 3 * 20 + 1, "R2 fresh interval after abort", k, 61);

    // R3 off-delay sweep
    for (int p = 0; p <= 12; p++) begin
      restart(1, 0, p);
      in_sig = 1'b1;
      step(1);
      chk(q == 1'b1, "R3 q follows input", q, 1);
      step(3);
      in_sig = 1'b0;
      wait_q(1'b0, 200, k);
      chk(k == p * 2 + 1, "R3 off-delay fall edge", k, p * 2 + 1);
      step(2);
      chk(et_bin == PW'(p), "R8 off count at preset", et_bin, p);
    end

    // R4 retrigger during hold-off
    restart(1, 0, 6);
    in_sig = 1'b1;
    step(2);
    in_sig = 1'b0;
    step(7);
    in_sig = 1'b1;
    step(2);
    chk(q == 1'b1, "R4 q kept high", q, 1);
    chk(et_bin == '0, "R4 count cancelled", et_bin, 0);
    in_sig = 1'b0;
    wait_q(1'b0, 200, k);
    chk(k == 13, "R4 full interval after retrigger", k, 13);

    // R5 pulse sweep
    for (int p = 0; p <= 12; p++) begin
      restart(2, 0, p);
      in_sig = 1'b1;
      if (p == 0) begin
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
          step(1);
          if (q) cnt++;
        end
        chk(cnt == 0, "R5 no pulse for preset 0", cnt, 0);
      end else begin
        wait_q(1'b1, 20, k);
        chk(k == 2, "R5 pulse start", k, 2);
        wait_q(1'b0, 200, k);
        chk(k == p * 2, "R5 pulse width", k, p * 2);
      end
    end

    // R6 retriggers inside a pulse are ignored
    restart(2, 0, 8);
    in_sig = 1'b1;
    wait_q(1'b1, 20, k);
    step(3);
    in_sig = 1'b0;
    step(2);
    in_sig = 1'b1;
    step(2);
    in_sig = 1'b0;
    wait_q(1'b0, 200, k);
    chk(k == 16 - 7, "R6 width unchanged by retrigger", k, 9);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      step(1);
      if (q) cnt++;
    end
    chk(cnt == 0, "R6 no second pulse", cnt, 0);

    // R7 time-base codes 0..7
    for (int tb = 0; tb < 8; tb++) begin
      restart(0, tb, 1);
      in_sig = 1'b1;
      wait_q(1'b1, 25000, k);
      chk(k == per(tb) + 1, "R7 time base period", k, per(tb) + 1);
    end

    // R8/R9 full count to largest preset with BCD decode
    restart(0, 0, 255);
    in_sig = 1'b1;
    for (int i = 1; i <= 520; i++) begin
      step(1);
      cnt = (i - 1) / 2;
      if (cnt > 255) cnt = 255;
      chk(et_bin == PW'(cnt), "R8 elapsed count", et_bin, cnt);
      dec = 0;
      for (int d = DG - 1; d >= 0; d--) dec = dec * 10 + et_bcd[4*d +: 4];
      chk(dec == cnt, "R9 bcd value", dec, cnt);
    end

    // R10 reset mid-run, then fresh timing with input held
    restart(0, 0, 5);
    in_sig = 1'b1;
    step(7);
    rst = 1'b1;
    step(1);
    chk(q == 1'b0 && en == 1'b0 && et_bin == '0, "R10 mid-run reset", {q, en, et_bin}, 0);
    rst = 1'b0;
    wait_q(1'b1, 200, k);
    chk(k == 11, "R10 timing after reset", k, 11);
    restart(1, 0, 4);
    in_sig = 1'b1;
    step(3);
    rst = 1'b1;
    step(1);
    chk(q == 1'b0, "R10 off-delay reset", q, 0);
    rst = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule